// File: doc/BRIEF.md
# Length-Decoded Serial Configuration Port

This block is the write path into the registers of a two-channel divider controller. A host drives an active-low enable, a serial clock and a data line. While enable is low, the block shifts in bits MSB first. When enable goes high, it picks the destination register from the number of bits it received. The serial word carries no address field.

There are three kinds of word:

- **8-bit word**: loads a configuration byte.
- **16-bit word**: loads a mode field and a staged 13-bit reference ratio. The mode field takes effect at once. The ratio waits in a staging buffer.
- **24-bit word**: loads a channel word. Its top bit picks the main or the secondary channel. The same commit copies the staged reference ratio into that channel's active ratio, so a channel's counter values change together.

The serial pins are sampled into the system clock. A frame is dropped if enable moves while the serial clock is high, and the block rejoins the stream once enable is high and the serial clock is low. Each commit emits a one-cycle strobe with a select code, which downstream logic can use.

Top module: `serial_cfg_port`

## Requirements
- R1: Bits are taken on serial clock rising edges, MSB first. The last bit shifted lands in bit 0 of the destination register.
- R2: A frame of exactly 8 bits loads `cfg_q` with the 8 received bits.
- R3: A frame of exactly 16 bits updates `rmode_q` (word bits 15:13) at once. It places bits 12:0 in a staging buffer, and this write does not change `ch0_r_q` or `ch1_r_q`.
- R4: A frame of exactly 24 bits uses word bit 23 as the steering bit (0 = main channel 0, 1 = secondary channel 1). The selected channel's A output gets bits 22:0, its R output gets the staged 13-bit ratio, and the other channel is unchanged.
- R5: A frame of any other length (for example 7, 9, 17, 25 or 32 bits) changes no register and raises no strobe.
- R6: Register outputs change only in the cycle after a clean enable release, never while bits are being shifted.
- R7: While enable is high, serial clock edges shift nothing and the bit count is held at zero.
- R8: If enable changes while the serial clock is high, the frame is discarded. The next frame that starts with enable high and the serial clock low is accepted.
- R9: `sdo` changes only after a serial clock falling edge. After the falling edge of bit i (i >= 24) of a frame, it shows bit i-23.
- R10: In a 24-bit word, N is bits 22:8 and A is bits 7:0. A committed word with N < A sets `nlta_err`, which stays set until reset, and the word is still committed.
- R11: Each commit gives a one-cycle `wr_stb` with `wr_sel` set as follows: 0 = configuration, 1 = R word, 2 = channel 0 A word, 3 = channel 1 A word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sen_n_in | input | 1 | Active-low frame enable, asynchronous |
| sdi_in | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, updated on serial clock falls |
| cfg_q | output | 8 | Configuration register |
| rmode_q | output | 3 | Immediate upper field of the R word |
| ch0_a_q | output | 23 | Channel 0 counter word (N in 22:8, A in 7:0) |
| ch1_a_q | output | 23 | Channel 1 counter word |
| ch0_r_q | output | 13 | Channel 0 active reference ratio |
| ch1_r_q | output | 13 | Channel 1 active reference ratio |
| nlta_err | output | 1 | Sticky flag: a committed word had N < A |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_sel | output | 2 | Register select code for the commit |

## Verification
Some properties hold on every cycle, so the assertions check them continuously:
- the strobe lasts one cycle and always follows a clean release;
- register outputs hold still between commits;
- `sdo` moves only after a detected serial clock fall;
- an idle enable keeps the bit count at zero;
- the error flag is sticky.

Other behaviour depends on the data, so only the bench scenarios can show it:
- which register a given frame length reaches;
- the MSB-first bit order;
- the per-channel steering;
- the staged ratio reaching the right channel only on its A write;
- the discard and recovery after an enable edge with the serial clock high;
- the 23-bit delay on `sdo`.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_CFG  = 2'd1,
    FK_R    = 2'd2,
    FK_A    = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    WS_CFG = 2'd0,
    WS_R   = 2'd1,
    WS_A0  = 2'd2,
    WS_A1  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cfgp_frontend.sv
module cfgp_frontend
  import cfgp_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int R_W   = 16,
  parameter int A_W   = 24,
  parameter int CW    = $clog2(A_W + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_s,
  input  logic           en_n_s,
  input  logic           sdi_s,
  output logic [A_W-1:0] shreg,
  output logic [CW-1:0]  bit_cnt,
  output frame_kind_e    kind,
  output logic           commit,
  output logic           sclk_rise,
  output logic           sclk_fall,
  output logic           insync,
  output logic           sdo
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic sclk_p, en_p;
  logic en_rise, en_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      en_p   <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      en_p   <= en_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_p;
  assign sclk_fall = ~sclk_s & sclk_p;
  assign en_rise   = en_n_s & ~en_p;
  assign en_edge   = en_n_s ^ en_p;

  // enable moving while serial clock is high breaks framing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 insync <= 1'b1;
    else if (en_edge && sclk_s) insync <= 1'b0;
    else if (en_n_s && !sclk_s) insync <= 1'b1;
  end

  assign commit = en_rise & insync & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (en_n_s) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise && insync) begin
      shreg <= {shreg[A_W-2:0], sdi_s};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sdo <= 1'b0;
    else if (sclk_fall) sdo <= shreg[A_W-1];
  end

  function automatic frame_kind_e decode_len(input logic [CW-1:0] n);
    if (n == CW'(CFG_W))    return FK_CFG;
    else if (n == CW'(R_W)) return FK_R;
    else if (n == CW'(A_W)) return FK_A;
    else                    return FK_NONE;
  endfunction

  assign kind = decode_len(bit_cnt);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int R_W    = 16,
  parameter int R_LO   = 13,
  parameter int A_W    = 24,
  parameter int ACNT_W = 8,
  parameter int NCH    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  frame_kind_e         kind,
  input  logic [A_W-1:0]      shreg,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [R_W-R_LO-1:0] rmode_q,
  output logic [A_W-2:0]      a_q  [NCH],
  output logic [R_LO-1:0]     r2_q [NCH],
  output logic                nlta_err,
  output logic                wr_stb,
  output logic [1:0]          wr_sel
);
  localparam int AV_W = A_W - 1;

  logic [R_LO-1:0] r_stage;
  logic            steer;
  logic            wr_cfg, wr_r, wr_a;

  assign steer  = shreg[A_W-1];
  assign wr_cfg = commit && (kind == FK_CFG);
  assign wr_r   = commit && (kind == FK_R);
  assign wr_a   = commit && (kind == FK_A);

  function automatic logic n_below_a(input logic [AV_W-1:0] w);
    return w[AV_W-1:ACNT_W] < (AV_W-ACNT_W)'(w[ACNT_W-1:0]);
  endfunction

  function automatic logic [1:0] sel_code(input frame_kind_e k, input logic s);
    case (k)
      FK_CFG:  return WS_CFG;
      FK_R:    return WS_R;
      default: return s ? WS_A1 : WS_A0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rmode_q <= '0;
      r_stage <= '0;
    end else begin
      if (wr_cfg) cfg_q <= shreg[CFG_W-1:0];
      if (wr_r) begin
        rmode_q <= shreg[R_W-1:R_LO];
        r_stage <= shreg[R_LO-1:0];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[c]  <= '0;
        r2_q[c] <= '0;
      end else if (wr_a && (32'(steer) == c)) begin
        a_q[c]  <= shreg[AV_W-1:0];
        r2_q[c] <= r_stage;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nlta_err <= 1'b0;
      wr_stb   <= 1'b0;
      wr_sel   <= 2'd0;
    end else begin
      if (wr_a && n_below_a(shreg[AV_W-1:0])) nlta_err <= 1'b1;
      wr_stb <= commit && (kind != FK_NONE);
      if (commit && (kind != FK_NONE)) wr_sel <= sel_code(kind, steer);
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgp_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int R_W    = 16,
  parameter int R_LO   = 13,
  parameter int A_W    = 24,
  parameter int ACNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_in,
  input  logic                sen_n_in,
  input  logic                sdi_in,
  output logic                sdo,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [R_W-R_LO-1:0] rmode_q,
  output logic [A_W-2:0]      ch0_a_q,
  output logic [A_W-2:0]      ch1_a_q,
  output logic [R_LO-1:0]     ch0_r_q,
  output logic [R_LO-1:0]     ch1_r_q,
  output logic                nlta_err,
  output logic                wr_stb,
  output logic [1:0]          wr_sel
);
  localparam int CW  = $clog2(A_W + 2);
  localparam int NCH = 2;

  logic [2:0]      pins_s;
  logic            sclk_s, en_n_s, sdi_s;
  logic [A_W-1:0]  shreg;
  logic [CW-1:0]   bit_cnt;
  frame_kind_e     kind;
  logic            commit, sclk_rise, sclk_fall, insync;
  logic [A_W-2:0]  a_q  [NCH];
  logic [R_LO-1:0] r2_q [NCH];

  cfgp_sync #(.W(3), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_in, sen_n_in, sdi_in}), .q(pins_s)
  );
  assign {sclk_s, en_n_s, sdi_s} = pins_s;

  cfgp_frontend #(.CFG_W(CFG_W), .R_W(R_W), .A_W(A_W), .CW(CW)) u_fe (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .en_n_s(en_n_s), .sdi_s(sdi_s),
    .shreg(shreg), .bit_cnt(bit_cnt), .kind(kind), .commit(commit),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .insync(insync), .sdo(sdo)
  );

  cfgp_regs #(.CFG_W(CFG_W), .R_W(R_W), .R_LO(R_LO), .A_W(A_W),
              .ACNT_W(ACNT_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .kind(kind), .shreg(shreg),
    .cfg_q(cfg_q), .rmode_q(rmode_q), .a_q(a_q), .r2_q(r2_q),
    .nlta_err(nlta_err), .wr_stb(wr_stb), .wr_sel(wr_sel)
  );

  assign ch0_a_q = a_q[0];
  assign ch1_a_q = a_q[1];
  assign ch0_r_q = r2_q[0];
  assign ch1_r_q = r2_q[1];
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int CFG_W = 8,
  parameter int A_W   = 24,
  parameter int R_LO  = 13,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_n_s,
  input logic             commit,
  input logic             sclk_fall,
  input logic             insync,
  input logic [CW-1:0]    bit_cnt,
  input logic             sdo,
  input logic [CFG_W-1:0] cfg_q,
  input logic [A_W-2:0]   ch0_a_q,
  input logic [A_W-2:0]   ch1_a_q,
  input logic [R_LO-1:0]  ch0_r_q,
  input logic [R_LO-1:0]  ch1_r_q,
  input logic             nlta_err,
  input logic             wr_stb
);
  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_stb_needs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(commit));

  p_commit_in_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> insync);

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(commit));

  p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ch0_a_q) || !$stable(ch1_a_q) || !$stable(ch0_r_q) || !$stable(ch1_r_q))
      |-> $past(commit));

  p_sdo_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_fall));

  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> (bit_cnt == '0));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nlta_err) |-> nlta_err);

  p_err_on_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nlta_err) |-> $past(commit));
endmodule

bind serial_cfg_port cfgp_chk #(.CFG_W(CFG_W), .A_W(A_W), .R_LO(R_LO), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n_s(en_n_s), .commit(commit),
  .sclk_fall(sclk_fall), .insync(insync), .bit_cnt(bit_cnt), .sdo(sdo),
  .cfg_q(cfg_q), .ch0_a_q(ch0_a_q), .ch1_a_q(ch1_a_q),
  .ch0_r_q(ch0_r_q), .ch1_r_q(ch1_r_q), .nlta_err(nlta_err), .wr_stb(wr_stb)
);

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  localparam int CLK_P = 10;
  localparam int HP    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0, sen_n_in = 1'b1, sdi_in = 1'b0;
  logic        sdo;
  logic [7:0]  cfg_q;
  logic [2:0]  rmode_q;
  logic [22:0] ch0_a_q, ch1_a_q;
  logic [12:0] ch0_r_q, ch1_r_q;
  logic        nlta_err, wr_stb;
  logic [1:0]  wr_sel;

  always #(CLK_P/2) clk = ~clk;

  serial_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sen_n_in(sen_n_in), .sdi_in(sdi_in),
    .sdo(sdo), .cfg_q(cfg_q), .rmode_q(rmode_q), .ch0_a_q(ch0_a_q), .ch1_a_q(ch1_a_q),
    .ch0_r_q(ch0_r_q), .ch1_r_q(ch1_r_q), .nlta_err(nlta_err),
    .wr_stb(wr_stb), .wr_sel(wr_sel)
  );

  int vectors = 0, fails = 0;
  int stb_cnt = 0;
  logic [1:0] last_sel = 2'd0;
  always @(posedge clk) if (rst_n && wr_stb) begin
    stb_cnt  <= stb_cnt + 1;
    last_sel <= wr_sel;
  end

  logic [7:0]  e_cfg = '0;
  logic [2:0]  e_mode = '0;
  logic [12:0] e_stage = '0;
  logic [22:0] e_a0 = '0, e_a1 = '0;
  logic [12:0] e_r0 = '0, e_r1 = '0;
  logic        e_err = 1'b0;
  logic        sdo_seen [1:40];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic n_lt_a(input logic [22:0] w);
    return int'(w[22:8]) < int'(w[7:0]);
  endfunction

  // model of a cleanly framed write of n bits
  task automatic model(input int n, input logic [31:0] w);
    if (n == 8) e_cfg = w[7:0];
    else if (n == 16) begin e_mode = w[15:13]; e_stage = w[12:0]; end
    else if (n == 24) begin
      if (n_lt_a(w[22:0])) e_err = 1'b1;
      if (w[23]) begin e_a1 = w[22:0]; e_r1 = e_stage; end
      else       begin e_a0 = w[22:0]; e_r0 = e_stage; end
    end
  endtask

  function automatic logic [1:0] sel_of(input int n, input logic s);
    return (n == 8) ? 2'd0 : (n == 16) ? 2'd1 : {1'b1, s};
  endfunction

  task automatic shift_bits(input int n, input logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_in = w[i];
      repeat (HP) @(negedge clk);
      sclk_in = 1'b1;
      repeat (HP) @(negedge clk);
      sclk_in = 1'b0;
      repeat (HP) @(negedge clk);
      if (n - i <= 40) sdo_seen[n - i] = sdo;
    end
  endtask

  task automatic send(input int n, input logic [31:0] w);
    @(negedge clk);
    sen_n_in = 1'b0;
    repeat (HP) @(negedge clk);
    shift_bits(n, w);
    sen_n_in = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_all(input int stb0, input int exp_d, input logic [1:0] exp_sel);
    chk("R2 cfg_q", 32'(cfg_q), 32'(e_cfg));
    chk("R3 rmode_q", 32'(rmode_q), 32'(e_mode));
    chk("R4 ch0_a_q", 32'(ch0_a_q), 32'(e_a0));
    chk("R4 ch1_a_q", 32'(ch1_a_q), 32'(e_a1));
    chk("R4 ch0_r_q", 32'(ch0_r_q), 32'(e_r0));
    chk("R4 ch1_r_q", 32'(ch1_r_q), 32'(e_r1));
    chk("R10 nlta_err", 32'(nlta_err), 32'(e_err));
    chk(exp_d == 0 ? "R5 strobe count" : "R11 strobe count", 32'(stb_cnt - stb0), 32'(exp_d));
    if (exp_d != 0) chk("R11 wr_sel", 32'(last_sel), 32'(exp_sel));
  endtask

  task automatic frame(input int n, input logic [31:0] w);
    int s0;
    logic [1:0] es;
    s0 = stb_cnt;
    es = sel_of(n, w[23]);
    send(n, w);
    model(n, w);
    check_all(s0, (n == 8 || n == 16 || n == 24) ? 1 : 0, es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int s0;
    int lens [7] = '{7, 8, 9, 16, 17, 24, 25};
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    check_all(stb_cnt, 0, 2'd0);
    chk("R9 sdo reset", 32'(sdo), 32'd0);

    // R1 R2: MSB first
    frame(8, 32'hA5);
    frame(8, 32'h01);
    // R3: mode immediate, stage hidden
    frame(16, 32'hB123);
    // R4: main channel gets stage copy
    frame(24, {8'h00, 15'h0100, 8'h10} >> 0);
    frame(16, 32'h4ABC);
    // R4: secondary channel
    frame(24, 32'h800F03 | 32'h800000);
    // R10: N < A sets sticky error, still commits
    frame(24, {8'h00, 1'b0, 15'h0001, 8'hFF});
    frame(24, {8'h00, 1'b1, 15'h7000, 8'h01});
    // R5: rejected lengths
    frame(7, 32'h55);
    frame(9, 32'h1FF);
    frame(17, 32'h1FFFF);
    frame(25, 32'h1FFFFFF);
    frame(0, 32'h0);

    // R9 + R5: 32-bit frame, sdo delayed by 23 bits, nothing written
    s0 = stb_cnt;
    send(32, 32'hC3A5_96E1);
    for (int i = 24; i <= 32; i++)
      chk($sformatf("R9 sdo bit %0d", i), 32'(sdo_seen[i]), 32'((32'hC3A5_96E1 >> (32 - (i - 23))) & 1));
    for (int i = 1; i <= 23; i++)
      if (i == 1 || i == 23) chk($sformatf("R9 sdo early %0d", i), 32'(sdo_seen[i]), 32'd0);
    check_all(s0, 0, 2'd0);

    // R7: clocks while enable high shift nothing
    sdi_in = 1'b1;
    for (int k = 0; k < 10; k++) begin
      repeat (HP) @(negedge clk); sclk_in = 1'b1;
      repeat (HP) @(negedge clk); sclk_in = 1'b0;
    end
    repeat (HP) @(negedge clk);
    frame(8, 32'h3C);

    // R8: enable falls while serial clock high -> discard
    s0 = stb_cnt;
    sclk_in = 1'b1; repeat (HP) @(negedge clk);
    sen_n_in = 1'b0; repeat (HP) @(negedge clk);
    sclk_in = 1'b0; repeat (HP) @(negedge clk);
    shift_bits(8, 32'h77);
    sen_n_in = 1'b1; repeat (10) @(negedge clk);
    check_all(s0, 0, 2'd0);
    // R8: enable rises while serial clock high -> discard
    s0 = stb_cnt;
    sen_n_in = 1'b0; repeat (HP) @(negedge clk);
    shift_bits(8, 32'h99);
    sclk_in = 1'b1; repeat (HP) @(negedge clk);
    sen_n_in = 1'b1; repeat (HP) @(negedge clk);
    sclk_in = 1'b0; repeat (10) @(negedge clk);
    check_all(s0, 0, 2'd0);
    // R8: recovery
    frame(8, 32'hE7);

    // constrained random mix
    for (int k = 0; k < 60; k++) begin
      int n;
      n = lens[$urandom_range(0, 6)];
      frame(n, $urandom());
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule